// File: doc/BRIEF.md
# Slave Read Path with Prefetch

This block carries 24-bit words from a processor core to an external bus master that reads them. The core writes words into the tail of a small FIFO. The head of that FIFO serves as the host-side receive register. The host pulls one word per read beat. A core-side service request flag tells the core when to supply more words. It is qualified separately into an interrupt output and a DMA request output. A host-side data-available flag shows whether a word is waiting.

A mode bit chooses between two ways of running the path. In prefetch mode the core is asked for data whenever there is room, so words are staged ahead of any host read. In fetch mode data is requested only while the host has a read transaction in progress. Between transactions the path is held empty and both flags stay low. A second control bit sets the usable depth to six words or three words. The mode bit can change only while the path is empty. Writing the mode bit to fetch also flushes the path.

Top module: `slave_read_path`

## Requirements
- R1: After reset the block is in prefetch mode (`fetch_mode` = 0), the path is empty, `host_avail` is 0 and `core_req` is 1.
- R2: In prefetch mode (`fetch_mode` = 0), `core_req` is 1 exactly when the path holds fewer words than its capacity, whatever the value of `host_active`.
- R3: The capacity is 6 words when `deep_sel` = 1 and 3 words when `deep_sel` = 0. A core write made while the path is full is dropped.
- R4: Words leave in the order they were written: `host_rdata` always shows the oldest stored word.
- R5: In fetch mode (`fetch_mode` = 1) with `host_active` = 0, `core_req` and `host_avail` are 0. Any stored words are discarded at the next clock edge, and core writes are ignored.
- R6: In fetch mode with `host_active` = 1, `core_req` is 1 exactly when the path is not full.
- R7: `host_avail` is 1 exactly when the path holds at least one word that the host may read.
- R8: A pulse on `cfg_wr` loads `cfg_fetch` (1 = fetch mode, 0 = prefetch mode) into `fetch_mode` only when the path is empty. While words are stored, the write is ignored.
- R9: An accepted `cfg_wr` with `cfg_fetch` = 1 forces `core_req` and `host_avail` to 0 in that cycle and leaves the path empty.
- R10: `core_irq` equals `core_req` AND `irq_en`, and `core_dma` equals `core_req` AND `dma_en`.
- R11: A `host_beat` while `host_avail` = 1 removes exactly one word. A `host_beat` while `host_avail` = 0 raises `host_wait` in that cycle and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_sel | input | 1 | Capacity select: 1 = six words, 0 = three words |
| cfg_wr | input | 1 | Strobe to write the mode bit |
| cfg_fetch | input | 1 | Mode value written by `cfg_wr`: 1 = fetch, 0 = prefetch |
| fetch_mode | output | 1 | Current mode bit |
| core_wr | input | 1 | Core write of one word |
| core_wdata | input | 24 | Word written by the core |
| core_req | output | 1 | Core-side service request |
| irq_en | input | 1 | Interrupt enable for the request |
| dma_en | input | 1 | DMA enable for the request |
| core_irq | output | 1 | Qualified interrupt request |
| core_dma | output | 1 | Qualified DMA request |
| host_active | input | 1 | Host read transaction in progress |
| host_beat | input | 1 | Host read beat on the receive register |
| host_rdata | output | 24 | Word presented to the host |
| host_avail | output | 1 | Data available for the host |
| host_wait | output | 1 | Beat found no data: wait or retry |

## Verification
The path is first filled past its capacity, once at the three-word setting and once at the six-word setting. This shows whether the capacity limit follows `deep_sel` and whether overflow words are dropped rather than corrupting the order. Streams that write and read in the same cycle show whether the count stays steady at full and at empty. Reads on an empty path show whether `host_wait` is raised. Mode writes are tried with the path loaded and with it empty, to show whether the write is locked while data is pending. In fetch mode, toggling `host_active` with and without stored data shows whether the path flushes between transactions and whether prefetch and fetch request behaviour differ.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic {
    MODE_PREFETCH = 1'b0,
    MODE_FETCH    = 1'b1
  } fetch_mode_e;
endpackage

// File: rtl/rdp_mode_ctrl.sv
module rdp_mode_ctrl
  import rdp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_fetch,
  input  logic        path_empty,
  output fetch_mode_e mode,
  output logic        flush_now
);
  fetch_mode_e mode_q;
  fetch_mode_e mode_d;
  logic        accept;

  always_comb begin
    accept = cfg_wr && path_empty;
    mode_d = mode_q;
    if (accept) mode_d = cfg_fetch ? MODE_FETCH : MODE_PREFETCH;
  end

  assign flush_now = accept && cfg_fetch;
  assign mode      = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= MODE_PREFETCH;
    else if (accept) mode_q <= mode_d;
  end

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !path_empty) |=> $stable(mode_q)); // R8
endmodule

// File: rtl/rdp_fifo.sv
module rdp_fifo #(
  parameter int WORD_W    = 24,
  parameter int DEPTH_MAX = 6,
  localparam int PTR_W    = $clog2(DEPTH_MAX),
  localparam int CNT_W    = $clog2(DEPTH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push_req,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop_req,
  input  logic [CNT_W-1:0]  cap,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic [WORD_W-1:0] head
);
  logic [WORD_W-1:0]    mem [DEPTH_MAX];
  logic [PTR_W-1:0]     wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CNT_W-1:0]     cnt_d;
  logic                 push_fire, pop_fire;
  logic [DEPTH_MAX-1:0] wr_hit;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH_MAX - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count >= cap);
  assign empty     = (count == '0);
  assign push_fire = push_req && !full && !clear;
  assign pop_fire  = pop_req && !empty && !clear;
  assign head      = mem[rd_ptr];

  for (genvar i = 0; i < DEPTH_MAX; i++) begin : g_slot
    assign wr_hit[i] = push_fire && (wr_ptr == PTR_W'(i));
  end

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    cnt_d    = count;
    if (clear) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_fire) wr_ptr_d = ptr_next(wr_ptr);
      if (pop_fire)  rd_ptr_d = ptr_next(rd_ptr);
      cnt_d = count + CNT_W'(push_fire) - CNT_W'(pop_fire);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH_MAX; i++) begin
      if (wr_hit[i]) mem[i] <= wdata;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req && !clear) |=> $stable(count)); // R3
endmodule

// File: rtl/rdp_flags.sv
module rdp_flags
  import rdp_pkg::*;
(
  input  fetch_mode_e mode,
  input  logic        host_active,
  input  logic        host_beat,
  input  logic        full,
  input  logic        empty,
  input  logic        flush_now,
  input  logic        irq_en,
  input  logic        dma_en,
  output logic        hold,
  output logic        pop_req,
  output logic        core_req,
  output logic        core_irq,
  output logic        core_dma,
  output logic        host_avail,
  output logic        host_wait
);
  always_comb begin
    hold       = (mode == MODE_FETCH) && !host_active;
    core_req   = !full && !hold && !flush_now;
    host_avail = !empty && !hold;
    pop_req    = host_beat && host_avail;
    host_wait  = host_beat && !host_avail;
    core_irq   = core_req && irq_en;
    core_dma   = core_req && dma_en;
  end
endmodule

// File: rtl/slave_read_path.sv
module slave_read_path
  import rdp_pkg::*;
#(
  parameter int WORD_W        = 24,
  parameter int DEPTH_DEEP    = 6,
  parameter int DEPTH_SHALLOW = 3,
  localparam int CNT_W        = $clog2(DEPTH_DEEP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deep_sel,
  input  logic              cfg_wr,
  input  logic              cfg_fetch,
  output logic              fetch_mode,
  input  logic              core_wr,
  input  logic [WORD_W-1:0] core_wdata,
  output logic              core_req,
  input  logic              irq_en,
  input  logic              dma_en,
  output logic              core_irq,
  output logic              core_dma,
  input  logic              host_active,
  input  logic              host_beat,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_avail,
  output logic              host_wait
);
  logic [1:0]       rst_sync;
  logic             rst_q;
  fetch_mode_e      mode;
  logic             flush_now, hold, pop_req, full, empty;
  logic [CNT_W-1:0] cap, fifo_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign cap        = deep_sel ? CNT_W'(DEPTH_DEEP) : CNT_W'(DEPTH_SHALLOW);
  assign fetch_mode = (mode == MODE_FETCH);

  rdp_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_q), .cfg_wr(cfg_wr), .cfg_fetch(cfg_fetch),
    .path_empty(empty), .mode(mode), .flush_now(flush_now)
  );

  rdp_fifo #(.WORD_W(WORD_W), .DEPTH_MAX(DEPTH_DEEP)) u_fifo (
    .clk(clk), .rst_n(rst_q), .clear(hold || flush_now),
    .push_req(core_wr), .wdata(core_wdata), .pop_req(pop_req), .cap(cap),
    .full(full), .empty(empty), .count(fifo_count), .head(host_rdata)
  );

  rdp_flags u_flags (
    .mode(mode), .host_active(host_active), .host_beat(host_beat),
    .full(full), .empty(empty), .flush_now(flush_now),
    .irq_en(irq_en), .dma_en(dma_en), .hold(hold), .pop_req(pop_req),
    .core_req(core_req), .core_irq(core_irq), .core_dma(core_dma),
    .host_avail(host_avail), .host_wait(host_wait)
  );

  AST_FETCH_IDLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_q)
    (fetch_mode && !host_active) |=> (fifo_count == '0)); // R5

  AST_WAIT_NO_POP: assert property (@(posedge clk) disable iff (!rst_q)
    (host_wait && !core_wr) |=> (fifo_count == '0)); // R11

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_q)
    (cfg_wr && cfg_fetch && empty) |=> (fifo_count == '0) && fetch_mode); // R9
endmodule

// File: tb/tb_slave_read_path.sv
module tb_slave_read_path;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        deep_sel, cfg_wr, cfg_fetch, core_wr, irq_en, dma_en;
  logic        host_active, host_beat;
  logic [23:0] core_wdata;
  logic        fetch_mode, core_req, core_irq, core_dma, host_avail, host_wait;
  logic [23:0] host_rdata;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [23:0] q[$];
  logic        m_mode;

  always #4 clk = ~clk;

  slave_read_path dut (
    .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel), .cfg_wr(cfg_wr),
    .cfg_fetch(cfg_fetch), .fetch_mode(fetch_mode), .core_wr(core_wr),
    .core_wdata(core_wdata), .core_req(core_req), .irq_en(irq_en),
    .dma_en(dma_en), .core_irq(core_irq), .core_dma(core_dma),
    .host_active(host_active), .host_beat(host_beat),
    .host_rdata(host_rdata), .host_avail(host_avail), .host_wait(host_wait)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge with inputs set: compare, then advance the model at posedge.
  task automatic step();
    int   cnt;
    logic full, hold, flush, e_req, e_avail;
    cnt     = q.size();
    full    = cnt >= (deep_sel ? 6 : 3);
    hold    = m_mode && !host_active;
    flush   = cfg_wr && cfg_fetch && (cnt == 0);
    e_req   = !full && !hold && !flush;
    e_avail = (cnt != 0) && !hold;
    #2;
    chk("R8 fetch_mode", {31'b0, fetch_mode}, {31'b0, m_mode});
    chk("R2 R6 R9 core_req", {31'b0, core_req}, {31'b0, e_req});
    chk("R7 host_avail", {31'b0, host_avail}, {31'b0, e_avail});
    chk("R10 core_irq", {31'b0, core_irq}, {31'b0, e_req && irq_en});
    chk("R10 core_dma", {31'b0, core_dma}, {31'b0, e_req && dma_en});
    chk("R11 host_wait", {31'b0, host_wait}, {31'b0, host_beat && !e_avail});
    if (e_avail) chk("R4 host_rdata", {8'b0, host_rdata}, {8'b0, q[0]});
    @(posedge clk);
    if (hold || flush) q.delete();
    else begin
      if (host_beat && e_avail) void'(q.pop_front());
      if (core_wr && !full) q.push_back(core_wdata);
    end
    if (cfg_wr && cnt == 0) m_mode = cfg_fetch;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic put(input logic [23:0] d);
    core_wr = 1'b1; core_wdata = d; step(); core_wr = 1'b0;
  endtask

  task automatic beat();
    host_beat = 1'b1; step(); host_beat = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; deep_sel = 1'b0; cfg_wr = 1'b0; cfg_fetch = 1'b0;
    core_wr = 1'b0; core_wdata = '0; irq_en = 1'b0; dma_en = 1'b0;
    host_active = 1'b0; host_beat = 1'b0; m_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    chk("R1 fetch_mode", {31'b0, fetch_mode}, 0);
    chk("R1 host_avail", {31'b0, host_avail}, 0);
    chk("R1 core_req", {31'b0, core_req}, 1);

    // R3 shallow capacity, overflow dropped; R2 with host idle
    for (int i = 0; i < 4; i++) put(24'h100 + 24'(i));
    #1 chk("R3 shallow full", {31'b0, core_req}, 0);
    for (int i = 0; i < 4; i++) beat();   // R4 order, last beat R11 wait

    // R3 deep capacity
    deep_sel = 1'b1; irq_en = 1'b1;
    for (int i = 0; i < 7; i++) put(24'hA00 + 24'(i));
    #1 chk("R3 deep full", {31'b0, core_req}, 0);
    dma_en = 1'b1;
    // concurrent write and read at full
    for (int i = 0; i < 5; i++) begin
      core_wr = 1'b1; core_wdata = 24'hB00 + 24'(i); host_beat = 1'b1;
      dma_en = i[0];
      step();
    end
    core_wr = 1'b0; host_beat = 1'b0;

    // R8 mode write ignored while loaded
    cfg_wr = 1'b1; cfg_fetch = 1'b1; step(); cfg_wr = 1'b0;
    chk("R8 locked", {31'b0, fetch_mode}, 0);
    for (int i = 0; i < 8; i++) beat();

    // R9 accepted write of fetch mode while host active
    host_active = 1'b1; cfg_wr = 1'b1; cfg_fetch = 1'b1;
    #1 chk("R9 req cleared", {31'b0, core_req}, 0);
    #0 step(); cfg_wr = 1'b0;
    chk("R8 accepted", {31'b0, fetch_mode}, 1);

    // R5 fetch mode, no host read: writes ignored
    host_active = 1'b0;
    for (int i = 0; i < 3; i++) put(24'hC00 + 24'(i));
    #1 chk("R5 avail low", {31'b0, host_avail}, 0);
    chk("R5 req low", {31'b0, core_req}, 0);

    // R6 fetch mode during a host read
    host_active = 1'b1; deep_sel = 1'b0;
    for (int i = 0; i < 4; i++) put(24'hD00 + 24'(i));
    beat(); beat();
    put(24'hD10);
    host_active = 1'b0; step();           // flush with data held
    host_active = 1'b1;
    #1 chk("R5 flushed", {31'b0, host_avail}, 0);
    #0 step();
    beat();                               // R11 wait on empty
    put(24'hE00); beat();

    // back to prefetch, R2 request independent of host_active
    host_active = 1'b0;
    cfg_wr = 1'b1; cfg_fetch = 1'b0; step(); cfg_wr = 1'b0;
    #1 chk("R2 prefetch req", {31'b0, core_req}, 1);
    #0 put(24'hF00); put(24'hF01);
    beat(); beat(); beat();
    idle(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule